// File: doc/BRIEF.md
# Clocked Serial Slave Transceiver

This block is the slave end of a three-wire synchronous serial link: a serial clock input, a data input and a data output. The remote master supplies the serial clock. The block oversamples that clock with its own operation clock through a synchroniser, finds the clock edges, and shifts one character in and one character out per transfer. Configuration inputs set the character length (7 or 8 bits), the bit order, the clock polarity and the data phase.

Host logic loads outgoing characters into a transmit buffer and collects incoming characters from a receive buffer. One interrupt line signals either the end of each character (single-transfer mode) or the transmit buffer becoming free (continuous mode). A sticky overrun flag reports a received character that replaced one the host had not yet read. Since edges come from oversampling, the serial clock must run no faster than one sixth of the operation clock.

Top module: `clkd_serial_slave`

## Requirements
- R1: After reset, sdo_o is 1, irq_o is 0, rx_valid_o is 0 and ovr_o is 0.
- R2: With cfg_lsb_first = 0 and cfg_len7 = 0, the first received bit lands in rx_data_o[7], and the first transmitted bit is tx_data_i[7]; after the eighth sampling edge rx_valid_o is 1.
- R3: With cfg_lsb_first = 1, the first bit received lands in rx_data_o[0] and the first bit transmitted is tx_data_i[0].
- R4: With cfg_len7 = 1, a character ends after seven sampling edges, rx_data_o[7] reads 0, and in MSB-first order transmission starts at tx_data_i[6].
- R5: With cfg_clk_inv = 1 the serial clock pin is used inverted: it idles high, and every edge rule applies to its inverse.
- R6: With cfg_early_phase = 0, the serial clock rising in its non-inverted sense drives the next output bit and the falling edge samples sdi_i; writing the transmit buffer does not change sdo_o before the first clock edge.
- R7: With cfg_early_phase = 1, the first output bit appears on sdo_o as soon as the character is loaded, before any clock edge; sdi_i is sampled on rising edges and later bits are driven on falling edges.
- R8: With cfg_cont_mode = 0, irq_o pulses high for exactly one clock per completed character and not on a transmit write.
- R9: With cfg_cont_mode = 1, irq_o pulses for one clock whenever the transmit buffer passes its character to the shifter, including when a write finds the shifter idle, and not when a character ends with the buffer empty.
- R10: When a character completes while rx_valid_o is 1 and no read strobe is given in that clock, ovr_o sets, rx_data_o takes the new character, and ovr_o stays set until an ovr_clr_i pulse.
- R11: While no transmit character is loaded, sdo_o keeps the last bit driven during any serial clocking.
- R12: A rx_rd_i pulse clears rx_valid_o when no character completes in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operation clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| cfg_len7 | input | 1 | 1 = 7-bit characters, 0 = 8-bit |
| cfg_lsb_first | input | 1 | 1 = LSB first, 0 = MSB first |
| cfg_clk_inv | input | 1 | 1 = serial clock inverted |
| cfg_early_phase | input | 1 | 1 = first bit driven before the clock starts |
| cfg_cont_mode | input | 1 | 1 = continuous mode (buffer-empty interrupt) |
| tx_wr_i | input | 1 | Transmit buffer write strobe |
| tx_data_i | input | DATA_W | Transmit character |
| rx_rd_i | input | 1 | Receive buffer read strobe |
| rx_data_o | output | DATA_W | Received character |
| rx_valid_o | output | 1 | Receive buffer holds an unread character |
| ovr_clr_i | input | 1 | Overrun flag clear strobe |
| ovr_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Interrupt pulse |

## Verification
A wrong bit counter shows as a shifted or truncated received character and as a completion pulse arriving one serial clock early or late; this is visible at rx_data_o and irq_o within the same character. A wrong transmit index or load decision corrupts sdo_o at the very next launch edge, which the bench captures one bit at a time just before each sampling edge. Flag faults surface at ovr_o and rx_valid_o a single operation clock after the completing edge.

// File: rtl/clkd_sio_pkg.sv
package clkd_sio_pkg;
   typedef enum logic {
      IRQ_DONE  = 1'b0,
      IRQ_EMPTY = 1'b1
   } irq_src_e;
endpackage

// File: rtl/clkd_sio_sync.sv
module clkd_sio_sync #(
   parameter int WIDTH = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkd_sio_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else if (s == 0) chain_q[s] <= async_i;
            else chain_q[s] <= chain_q[(s > 0) ? s - 1 : 0];
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkd_sio_tx.sv
module clkd_sio_tx #(
   parameter int DATA_W = 8,
   parameter int CNT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              lsb_first_i,
   input  logic              len7_i,
   input  logic              early_i,
   input  logic              launch_i,
   input  logic              done_i,
   input  logic              cnt_zero_i,
   input  logic [CNT_W-1:0]  idx_i,
   output logic              sdo_o,
   output logic              load_o,
   output logic              act_o
);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   logic [DATA_W-1:0] buf_q, word_q, word_src;
   logic              full_q, act_q, sdo_q;

   function automatic logic pick(input logic [DATA_W-1:0] w,
                                 input logic [CNT_W-1:0] i,
                                 input logic lsb, input logic short_len);
      logic [CNT_W-1:0] top, pos;
      top = short_len ? CNT_W'(DATA_W-2) : CNT_W'(DATA_W-1);
      pos = lsb ? i : (top - i);
      return w[pos[IDX_W-1:0]];
   endfunction

   assign load_o   = full_q && (done_i || (!act_q && cnt_zero_i));
   assign word_src = load_o ? buf_q : word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         word_q <= '0;
         full_q <= 1'b0;
         act_q  <= 1'b0;
         sdo_q  <= 1'b1;
      end else begin
         if (wr_i) buf_q <= wdata_i;
         if (wr_i) full_q <= 1'b1;
         else if (load_o) full_q <= 1'b0;
         if (load_o) begin
            word_q <= buf_q;
            act_q  <= 1'b1;
         end else if (done_i) begin
            act_q  <= 1'b0;
         end
         if (launch_i && (act_q || load_o))
            sdo_q <= pick(word_src, idx_i, lsb_first_i, len7_i);
         else if (load_o && early_i)
            sdo_q <= pick(buf_q, '0, lsb_first_i, len7_i);
      end
   end

   assign sdo_o = sdo_q;
   assign act_o = act_q;
endmodule

// File: rtl/clkd_sio_rx.sv
module clkd_sio_rx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_i,
   input  logic              d_i,
   input  logic              done_i,
   input  logic              len7_i,
   input  logic              lsb_first_i,
   input  logic              rd_i,
   input  logic              ovr_clr_i,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o,
   output logic              ovr_o
);
   logic [DATA_W-1:0] sh_q, nx, buf_q;
   logic              valid_q, ovr_q;

   always_comb begin
      if (lsb_first_i) begin
         if (len7_i) nx = {1'b0, d_i, sh_q[DATA_W-2:1]};
         else        nx = {d_i, sh_q[DATA_W-1:1]};
      end else begin
         nx = {sh_q[DATA_W-2:0], d_i};
         if (len7_i) nx[DATA_W-1] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         buf_q   <= '0;
         valid_q <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         if (smp_i) sh_q <= nx;
         if (done_i) begin
            buf_q   <= nx;
            valid_q <= 1'b1;
         end else if (rd_i) begin
            valid_q <= 1'b0;
         end
         if (done_i && valid_q && !rd_i) ovr_q <= 1'b1;
         else if (ovr_clr_i) ovr_q <= 1'b0;
      end
   end

   assign data_o  = buf_q;
   assign valid_o = valid_q;
   assign ovr_o   = ovr_q;
endmodule

// File: rtl/clkd_serial_slave.sv
module clkd_serial_slave
   import clkd_sio_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sdi_i,
   output logic              sdo_o,
   input  logic              cfg_len7,
   input  logic              cfg_lsb_first,
   input  logic              cfg_clk_inv,
   input  logic              cfg_early_phase,
   input  logic              cfg_cont_mode,
   input  logic              tx_wr_i,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic              rx_rd_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_valid_o,
   input  logic              ovr_clr_i,
   output logic              ovr_o,
   output logic              irq_o
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_FULL  = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

   generate
      if (DATA_W < 3) begin : g_bad_width
         $error("clkd_serial_slave: DATA_W must be at least 3");
      end
   endgenerate

   logic             ck_s, d_s, ck_d;
   logic             rise, fall, smp, lnch, launch_ok, char_done, cnt_zero;
   logic [CNT_W-1:0] cnt_q, last;
   logic             tx_load, tx_act, irq_q;
   irq_src_e         irq_src;

   // polarity applied ahead of the synchroniser so a change while idle cannot fake an edge
   clkd_sio_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) sync_i (
      .clk(clk), .rst_n(rst_n),
      .async_i({sclk_i ^ cfg_clk_inv, sdi_i}),
      .sync_o({ck_s, d_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ck_d <= 1'b0;
      else ck_d <= ck_s;
   end

   assign rise      = ck_s & ~ck_d;
   assign fall      = ~ck_s & ck_d;
   assign smp       = cfg_early_phase ? rise : fall;
   assign lnch      = cfg_early_phase ? fall : rise;
   assign last      = cfg_len7 ? LAST_SHORT : LAST_FULL;
   assign cnt_zero  = (cnt_q == '0);
   assign char_done = smp && (cnt_q == last);
   assign launch_ok = lnch && (!cfg_early_phase || !cnt_zero);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (char_done) cnt_q <= '0;
      else if (smp) cnt_q <= cnt_q + 1'b1;
   end

   clkd_sio_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) tx_i (
      .clk(clk), .rst_n(rst_n),
      .wr_i(tx_wr_i), .wdata_i(tx_data_i),
      .lsb_first_i(cfg_lsb_first), .len7_i(cfg_len7), .early_i(cfg_early_phase),
      .launch_i(launch_ok), .done_i(char_done), .cnt_zero_i(cnt_zero),
      .idx_i(cnt_q), .sdo_o(sdo_o), .load_o(tx_load), .act_o(tx_act)
   );

   clkd_sio_rx #(.DATA_W(DATA_W)) rx_i (
      .clk(clk), .rst_n(rst_n),
      .smp_i(smp), .d_i(d_s), .done_i(char_done),
      .len7_i(cfg_len7), .lsb_first_i(cfg_lsb_first),
      .rd_i(rx_rd_i), .ovr_clr_i(ovr_clr_i),
      .data_o(rx_data_o), .valid_o(rx_valid_o), .ovr_o(ovr_o)
   );

   assign irq_src = cfg_cont_mode ? IRQ_EMPTY : IRQ_DONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else irq_q <= (irq_src == IRQ_EMPTY) ? tx_load : char_done;
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/clkd_serial_slave_chk.sv
module clkd_serial_slave_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cont,
   input logic              len7,
   input logic              irq,
   input logic              ovr,
   input logic              ovr_clr,
   input logic              rx_rd,
   input logic              rx_valid,
   input logic [DATA_W-1:0] rx_data,
   input logic              sdo,
   input logic              tx_load,
   input logic              tx_act,
   input logic              done
);
   // R8
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R9
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cont && irq) |-> $past(tx_load));
   // R10
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !ovr_clr) |=> ovr);
   // R10
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(rx_valid));
   // R4
   short_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && len7) |=> !rx_data[DATA_W-1]);
   // R11
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_act && !tx_load) |=> $stable(sdo));
   // R12
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && !done) |=> !rx_valid);
endmodule

bind clkd_serial_slave clkd_serial_slave_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cont(cfg_cont_mode), .len7(cfg_len7),
   .irq(irq_o), .ovr(ovr_o), .ovr_clr(ovr_clr_i), .rx_rd(rx_rd_i),
   .rx_valid(rx_valid_o), .rx_data(rx_data_o), .sdo(sdo_o),
   .tx_load(tx_load), .tx_act(tx_act), .done(char_done)
);

// File: tb/clkd_serial_slave_tb_top.sv
`timescale 1ns/1ps
module clkd_serial_slave_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk_e = 1'b0;
   logic sdi = 1'b1;
   logic sdo;
   logic len7 = 1'b0, lsb = 1'b0, inv = 1'b0, early = 1'b0, cont = 1'b0;
   logic tx_wr = 1'b0, rx_rd = 1'b0, ovr_clr = 1'b0;
   logic [7:0] tx_data = '0;
   logic [7:0] rx_data;
   logic rx_valid, ovr, irq;
   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;

   always #4 clk = ~clk;

   clkd_serial_slave dut_i (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk_e ^ inv), .sdi_i(sdi), .sdo_o(sdo),
      .cfg_len7(len7), .cfg_lsb_first(lsb), .cfg_clk_inv(inv),
      .cfg_early_phase(early), .cfg_cont_mode(cont),
      .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_rd_i(rx_rd),
      .rx_data_o(rx_data), .rx_valid_o(rx_valid), .ovr_clr_i(ovr_clr),
      .ovr_o(ovr), .irq_o(irq)
   );

   always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_write(input logic [7:0] d);
      @(negedge clk); tx_wr = 1'b1; tx_data = d;
      @(negedge clk); tx_wr = 1'b0;
      wait_n(4);
   endtask

   task automatic host_read();
      @(negedge clk); rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
   endtask

   // master side: sends mw, returns what was seen on sdo just before each sampling edge
   task automatic run_char(input logic [7:0] mw, input int n, output logic [7:0] got);
      got = '0;
      for (int i = 0; i < n; i++) begin
         int pos;
         pos = lsb ? i : (n - 1 - i);
         if (!early) begin
            @(negedge clk); sclk_e = 1'b1; sdi = mw[pos];
            wait_n(4);
            got[pos] = sdo;
            sclk_e = 1'b0;
            wait_n(4);
         end else begin
            @(negedge clk); sdi = mw[pos];
            wait_n(4);
            got[pos] = sdo;
            sclk_e = 1'b1;
            wait_n(4);
            sclk_e = 1'b0;
            wait_n(4);
         end
      end
      wait_n(2);
   endtask

   task automatic t_reset();
      chk("R1 sdo", sdo, 1'b1);
      chk("R1 irq", irq, 1'b0);
      chk("R1 rx_valid", rx_valid, 1'b0);
      chk("R1 ovr", ovr, 1'b0);
   endtask

   task automatic t_msb8();
      logic [7:0] got;
      int c0;
      len7 = 0; lsb = 0; early = 0; cont = 0;
      c0 = irq_cnt;
      host_write(8'h5A);
      chk("R6 sdo before clock", sdo, 1'b1);
      chk("R8 no irq on write", irq_cnt, c0);
      run_char(8'h3C, 8, got);
      chk("R2 tx msb first", got, 8'h5A);
      chk("R2 rx msb first", rx_data, 8'h3C);
      chk("R2 rx_valid", rx_valid, 1'b1);
      chk("R8 irq per char", irq_cnt, c0 + 1);
      host_read();
      wait_n(1);
      chk("R12 rd clears valid", rx_valid, 1'b0);
   endtask

   task automatic t_lsb8();
      logic [7:0] got;
      lsb = 1;
      host_write(8'h01);
      run_char(8'h0E, 8, got);
      chk("R3 tx lsb first", got, 8'h01);
      chk("R3 rx lsb first", rx_data, 8'h0E);
      host_read();
   endtask

   task automatic t_short_early();
      logic [7:0] got;
      int c0;
      lsb = 0; len7 = 1; early = 1;
      c0 = irq_cnt;
      chk("R11 sdo before load", sdo, 1'b0);
      host_write(8'h4A);
      chk("R7 first bit early", sdo, 1'b1);
      run_char(8'hB5, 7, got);
      chk("R4 tx 7 bit", got, 8'h4A);
      chk("R4 rx 7 bit top zero", rx_data, 8'h35);
      chk("R4 ends after 7 edges", rx_valid, 1'b1);
      chk("R7 irq count", irq_cnt, c0 + 1);
      host_read();
   endtask

   task automatic t_inverted();
      logic [7:0] got;
      len7 = 0; early = 0; inv = 1;
      wait_n(4);
      host_write(8'hC3);
      run_char(8'h5A, 8, got);
      chk("R5 tx inverted clock", got, 8'hC3);
      chk("R5 rx inverted clock", rx_data, 8'h5A);
   endtask

   task automatic t_hold_overrun();
      logic [7:0] got;
      chk("R10 no ovr yet", ovr, 1'b0);
      run_char(8'h77, 8, got);
      chk("R11 sdo holds", got, 8'hFF);
      chk("R10 ovr set", ovr, 1'b1);
      chk("R10 new data", rx_data, 8'h77);
      wait_n(6);
      chk("R10 ovr sticky", ovr, 1'b1);
      @(negedge clk); ovr_clr = 1'b1;
      @(negedge clk); ovr_clr = 1'b0;
      wait_n(1);
      chk("R10 ovr cleared", ovr, 1'b0);
      host_read();
   endtask

   task automatic t_cont();
      logic [7:0] got;
      int c0;
      inv = 0; cont = 1;
      wait_n(4);
      c0 = irq_cnt;
      host_write(8'h11);
      chk("R9 irq on idle load", irq_cnt, c0 + 1);
      host_write(8'h22);
      chk("R9 no irq while busy", irq_cnt, c0 + 1);
      run_char(8'h0F, 8, got);
      chk("R9 first char", got, 8'h11);
      chk("R9 rx first", rx_data, 8'h0F);
      chk("R9 irq on reload", irq_cnt, c0 + 2);
      host_read();
      run_char(8'hF0, 8, got);
      chk("R9 second char", got, 8'h22);
      chk("R9 no irq when empty", irq_cnt, c0 + 2);
      chk("R9 rx second", rx_data, 8'hF0);
      host_read();
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(3);
      t_reset();
      t_msb8();
      t_lsb8();
      t_short_early();
      t_inverted();
      t_hold_overrun();
      t_cont();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule